// File: doc/BRIEF.md
# External Interrupt Pin Selector

This block turns the synchronized levels of six 16-pin ports into sixteen edge-triggered interrupt channels. Channel n always looks at pin n; software only picks which port that pin comes from, through a 3-bit port index per channel. A rising or falling transition on the watched pin, if that direction is enabled for the channel, sets the channel's sticky flag. The flag stays set until software writes a one to the matching bit of a write-one-to-clear alias.

Two request lines leave the block. One carries the even-numbered channels and the other the odd-numbered channels, each being the OR of the flags whose enable bit is set. Registers sit on a simple 32-bit word bus: a write strobe with address and data, and a read port that is decoded without a clock.

Top module: `extint_router`

## Requirements
- R1: After reset every register reads zero at 0x100, 0x104, 0x108, 0x10C, 0x110, 0x114 and 0x11C, and both request outputs are low.
- R2: Channel n (0..7) takes its port index from bits [4n+2:4n] of the register at 0x100, and channel n (8..15) takes it from bits [4(n-8)+2:4(n-8)] of the register at 0x104. Bit 4k+3 of each field reads back as zero. With index p, channel n watches bit 16p+n of `pin_lvl`.
- R3: Bit n of the rise-enable register at 0x108 lets a low-to-high change of the watched level set flag n. The flag is readable after the next rising clock edge.
- R4: Bit n of the fall-enable register at 0x10C lets a high-to-low change set flag n. Both enables may be set together. A direction whose enable is clear sets nothing.
- R5: A write to 0x11C clears every flag whose data bit is one and leaves flags whose data bit is zero untouched. 0x11C reads as zero.
- R6: If an edge on channel n and a clear of bit n land in the same cycle, flag n ends up set.
- R7: Flags at 0x114 (bit n = channel n) stay set until cleared, whatever the interrupt enable register holds.
- R8: `irq_even` is high exactly when some even channel has both its flag and its enable bit at 0x110 set. `irq_odd` does the same for the odd channels.
- R9: A port index of 6 or 7 selects no pin, and the channel never sets its flag while that index is held.
- R10: Changing a channel's port index creates no edge. The first level seen after the change, or after reset, is only recorded.
- R11: Writes to 0x114 and to unmapped addresses have no effect, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | 96 | Synchronized pin levels; bit 16p+i is pin i of port p |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, not clocked |
| irq_even | output | 1 | Request from enabled flags on even channels |
| irq_odd | output | 1 | Request from enabled flags on odd channels |

## Verification
Two pairs of functions can land in the same cycle. The first is a detected edge and a write-one-to-clear of the same flag. The second is a port-index change and a level difference between the old and new port. The bench provokes the first by toggling a pin in the same step as a clear write to that bit, and expects the flag to read as set. It provokes the second by switching a channel to a port whose pin sits at the opposite level, and expects the flag to stay clear. A long random phase mixes pin flips with writes to every register, including index changes and clears. Each step is judged against a bench model of flags and request lines.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int NUM_CH      = 16;
    localparam int NUM_PORTS   = 6;
    localparam int PORT_W      = 16;
    localparam int PIN_W       = NUM_PORTS * PORT_W;
    localparam int SEL_W       = 3;
    localparam int FIELD_W     = 4;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 12;
    localparam int CH_PER_WORD = DATA_W / FIELD_W;

    localparam logic [ADDR_W-1:0] A_SEL_LO = 12'h100;
    localparam logic [ADDR_W-1:0] A_SEL_HI = 12'h104;
    localparam logic [ADDR_W-1:0] A_RISE   = 12'h108;
    localparam logic [ADDR_W-1:0] A_FALL   = 12'h10C;
    localparam logic [ADDR_W-1:0] A_IEN    = 12'h110;
    localparam logic [ADDR_W-1:0] A_FLAG   = 12'h114;
    localparam logic [ADDR_W-1:0] A_CLR    = 12'h11C;

    typedef enum logic [2:0] {
        R_NONE, R_SEL_LO, R_SEL_HI, R_RISE, R_FALL, R_IEN, R_FLAG, R_CLR
    } reg_id_e;

    typedef logic [NUM_CH-1:0] ch_vec_t;
    typedef logic [SEL_W-1:0]  port_idx_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_en_t;

    function automatic reg_id_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            A_SEL_LO: return R_SEL_LO;
            A_SEL_HI: return R_SEL_HI;
            A_RISE:   return R_RISE;
            A_FALL:   return R_FALL;
            A_IEN:    return R_IEN;
            A_FLAG:   return R_FLAG;
            A_CLR:    return R_CLR;
            default:  return R_NONE;
        endcase
    endfunction

    // Channel n belongs to the even group when n is even.
    function automatic ch_vec_t parity_mask(logic odd);
        ch_vec_t m;
        for (int i = 0; i < NUM_CH; i++) begin
            m[i] = ((i % 2) == 1) == odd;
        end
        return m;
    endfunction

    function automatic reg_id_e sel_reg_of(int ch);
        return (ch / CH_PER_WORD == 0) ? R_SEL_LO : R_SEL_HI;
    endfunction

endpackage

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    input  ch_vec_t                         flags_i,
    output logic [NUM_CH-1:0][SEL_W-1:0]    sel_q,
    output logic [NUM_CH-1:0]               sel_chg,
    output ch_vec_t                         rise_q,
    output ch_vec_t                         fall_q,
    output ch_vec_t                         ien_q,
    output ch_vec_t                         clr_mask,
    output logic [DATA_W-1:0]               bus_rdata
);

    reg_id_e rid;
    logic    unused_field_msbs;

    assign rid = decode_addr(bus_addr);
    assign unused_field_msbs = ^{bus_wdata[31], bus_wdata[27], bus_wdata[23], bus_wdata[19]};

    // Per-channel port index storage (R2) and change detection (R10)
    for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
        localparam int SLOT = n % CH_PER_WORD;
        port_idx_t new_idx;
        logic      hit;

        assign new_idx    = bus_wdata[SLOT*FIELD_W +: SEL_W];
        assign hit        = bus_we && (rid == sel_reg_of(n));
        assign sel_chg[n] = hit && (new_idx != sel_q[n]);

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[n] <= '0;
            end else if (hit) begin
                sel_q[n] <= new_idx;
            end
        end
    end

    // Edge and interrupt enables
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= '0;
            fall_q <= '0;
            ien_q  <= '0;
        end else if (bus_we) begin
            case (rid)
                R_RISE:  rise_q <= bus_wdata[NUM_CH-1:0];
                R_FALL:  fall_q <= bus_wdata[NUM_CH-1:0];
                R_IEN:   ien_q  <= bus_wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    // Write-one-to-clear alias (R5)
    assign clr_mask = (bus_we && rid == R_CLR) ? bus_wdata[NUM_CH-1:0] : '0;

    // Read decode
    always_comb begin
        bus_rdata = '0;
        case (rid)
            R_SEL_LO: begin
                for (int k = 0; k < CH_PER_WORD; k++) begin
                    bus_rdata[k*FIELD_W +: SEL_W] = sel_q[k];
                end
            end
            R_SEL_HI: begin
                for (int k = 0; k < CH_PER_WORD; k++) begin
                    bus_rdata[k*FIELD_W +: SEL_W] = sel_q[k + CH_PER_WORD];
                end
            end
            R_RISE:  bus_rdata[NUM_CH-1:0] = rise_q;
            R_FALL:  bus_rdata[NUM_CH-1:0] = fall_q;
            R_IEN:   bus_rdata[NUM_CH-1:0] = ien_q;
            R_FLAG:  bus_rdata[NUM_CH-1:0] = flags_i;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/extint_chan.sv
module extint_chan
    import extint_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] col,
    input  port_idx_t            sel,
    input  logic                 sel_chg,
    input  edge_en_t             en,
    output logic                 evt
);

    logic lvl;
    logic prev_q;
    logic seen_q;

    // An index past the last port selects a constant low (R9)
    always_comb begin
        lvl = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel == port_idx_t'(p)) begin
                lvl = col[p];
            end
        end
    end

    // The first sample after reset or a port switch only primes the history (R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (sel_chg) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            seen_q <= 1'b1;
        end
    end

    assign evt = seen_q && ((en.rise && lvl && !prev_q) ||
                            (en.fall && !lvl && prev_q));

endmodule

// File: rtl/extint_flags.sv
module extint_flags
    import extint_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t evt,
    input  ch_vec_t clr_mask,
    input  ch_vec_t ien,
    output ch_vec_t flags_q,
    output logic    irq_even,
    output logic    irq_odd
);

    localparam ch_vec_t EVEN_M = parity_mask(1'b0);
    localparam ch_vec_t ODD_M  = parity_mask(1'b1);

    ch_vec_t live;

    // Set has priority over clear (R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | evt;
        end
    end

    assign live     = flags_q & ien;
    assign irq_even = |(live & EVEN_M);
    assign irq_odd  = |(live & ODD_M);

endmodule

// File: rtl/extint_router.sv
module extint_router
    import extint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_W-1:0]  pin_lvl,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_even,
    output logic              irq_odd
);

    logic [NUM_CH-1:0][SEL_W-1:0]     sel_q;
    logic [NUM_CH-1:0]                sel_chg;
    ch_vec_t                          rise_q;
    ch_vec_t                          fall_q;
    ch_vec_t                          ien_q;
    ch_vec_t                          clr_mask;
    ch_vec_t                          flags_q;
    ch_vec_t                          evt_v;
    logic [NUM_CH-1:0][NUM_PORTS-1:0] col_v;

    extint_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags_i   (flags_q),
        .sel_q     (sel_q),
        .sel_chg   (sel_chg),
        .rise_q    (rise_q),
        .fall_q    (fall_q),
        .ien_q     (ien_q),
        .clr_mask  (clr_mask),
        .bus_rdata (bus_rdata)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        edge_en_t en;

        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
            assign col_v[n][p] = pin_lvl[p*PORT_W + n];
        end

        assign en.rise = rise_q[n];
        assign en.fall = fall_q[n];

        extint_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .col     (col_v[n]),
            .sel     (sel_q[n]),
            .sel_chg (sel_chg[n]),
            .en      (en),
            .evt     (evt_v[n])
        );
    end

    extint_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_v),
        .clr_mask (clr_mask),
        .ien      (ien_q),
        .flags_q  (flags_q),
        .irq_even (irq_even),
        .irq_odd  (irq_odd)
    );

endmodule

// File: rtl/extint_router_chk.sv
module extint_router_chk
    import extint_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_we,
    input logic [ADDR_W-1:0]            bus_addr,
    input ch_vec_t                      clr_data,
    input ch_vec_t                      flags,
    input ch_vec_t                      evt,
    input ch_vec_t                      ien,
    input logic [NUM_CH-1:0][SEL_W-1:0] sel,
    input logic [NUM_CH-1:0]            sel_chg,
    input logic                         irq_even,
    input logic                         irq_odd
);

    a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR) |=>
            ((flags & $past(clr_data) & ~$past(evt)) == '0));

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    a_r7_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_CLR) |=> ((flags & $past(flags)) == $past(flags)));

    a_r8_quiet_lines: assert property (@(posedge clk) disable iff (rst)
        (ien == '0 || flags == '0) |-> (!irq_even && !irq_odd));

    a_r11_flag_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_FLAG && evt == '0) |=> (flags == $past(flags)));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        a_r9_dead_port: assert property (@(posedge clk) disable iff (rst)
            (sel[n] >= SEL_W'(NUM_PORTS)) |-> !evt[n]);

        a_r10_no_switch_edge: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(sel_chg[n])) |-> !evt[n]);
    end

endmodule

bind extint_router extint_router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .clr_data (bus_wdata[extint_pkg::NUM_CH-1:0]),
    .flags    (flags_q),
    .evt      (evt_v),
    .ien      (ien_q),
    .sel      (sel_q),
    .sel_chg  (sel_chg),
    .irq_even (irq_even),
    .irq_odd  (irq_odd)
);

// File: tb/extint_router_test.sv
`timescale 1ns/1ps
module extint_router_test;
    import extint_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PIN_W-1:0]  pin_lvl = '0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = A_FLAG;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_even;
    logic              irq_odd;

    always #4 clk = ~clk;

    extint_router uut (
        .clk       (clk),
        .rst       (rst),
        .pin_lvl   (pin_lvl),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_even  (irq_even),
        .irq_odd   (irq_odd)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench model of the requirements
    int               m_sel [NUM_CH];
    logic [15:0]      m_rise = '0, m_fall = '0, m_ien = '0, m_flags = '0;
    logic [15:0]      m_prev = '0, m_valid = '0;
    logic [PIN_W-1:0] cur_pins = '0;

    initial for (int n = 0; n < NUM_CH; n++) m_sel[n] = 0;

    function automatic int pidx(int port, int n);
        return port * PORT_W + n;
    endfunction

    function automatic logic m_lvl(int n, logic [PIN_W-1:0] p);
        if (m_sel[n] < NUM_PORTS) return p[pidx(m_sel[n], n)];
        return 1'b0;
    endfunction

    function automatic logic [1:0] m_irq();
        return {|(m_flags & m_ien & 16'hAAAA), |(m_flags & m_ien & 16'h5555)};
    endfunction

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // One clock of stimulus, then compare flags and lines against the model
    task automatic step(input logic [PIN_W-1:0] pins, input bit we,
                        input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input string tag);
        logic [15:0] ev;
        logic [15:0] clr;
        int          nsel [NUM_CH];
        logic        l;
        pin_lvl   = pins;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        for (int n = 0; n < NUM_CH; n++) nsel[n] = m_sel[n];
        if (we && a == A_SEL_LO)
            for (int k = 0; k < 8; k++) nsel[k] = int'(d[4*k +: 3]);
        if (we && a == A_SEL_HI)
            for (int k = 0; k < 8; k++) nsel[k+8] = int'(d[4*k +: 3]);
        for (int n = 0; n < NUM_CH; n++) begin
            l = m_lvl(n, pins);
            ev[n] = m_valid[n] && ((l && !m_prev[n] && m_rise[n]) ||
                                   (!l && m_prev[n] && m_fall[n]));
            if (nsel[n] != m_sel[n]) begin
                m_valid[n] = 1'b0;
                m_prev[n]  = 1'b0;
            end else begin
                m_valid[n] = 1'b1;
                m_prev[n]  = l;
            end
        end
        clr = (we && a == A_CLR) ? d[15:0] : 16'h0;
        @(posedge clk);
        @(negedge clk);
        bus_we  = 1'b0;
        m_flags = (m_flags & ~clr) | ev;
        for (int n = 0; n < NUM_CH; n++) m_sel[n] = nsel[n];
        if (we && a == A_RISE) m_rise = d[15:0];
        if (we && a == A_FALL) m_fall = d[15:0];
        if (we && a == A_IEN)  m_ien  = d[15:0];
        bus_addr = A_FLAG;
        #1;
        chk_eq({tag, " flags"}, bus_rdata, {16'h0, m_flags});
        chk_eq({tag, " irq"}, {30'h0, irq_odd, irq_even}, {30'h0, m_irq()});
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
        step(cur_pins, 1'b1, a, d, tag);
    endtask

    task automatic pins_to(input logic [PIN_W-1:0] p, input string tag);
        cur_pins = p;
        step(cur_pins, 1'b0, A_FLAG, 32'h0, tag);
    endtask

    function automatic logic [PIN_W-1:0] bit_at(int i);
        logic [PIN_W-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [PIN_W-1:0] flip;
        logic [ADDR_W-1:0] alist [8];
        void'($urandom(32'd20240611));
        alist = '{A_SEL_LO, A_SEL_HI, A_RISE, A_FALL, A_IEN, A_CLR, A_FLAG, 12'h118};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_SEL_LO, d); chk_eq("R1 sel_lo", d, 0);
        rd(A_SEL_HI, d); chk_eq("R1 sel_hi", d, 0);
        rd(A_RISE, d);   chk_eq("R1 rise", d, 0);
        rd(A_FALL, d);   chk_eq("R1 fall", d, 0);
        rd(A_IEN, d);    chk_eq("R1 ien", d, 0);
        rd(A_FLAG, d);   chk_eq("R1 flags", d, 0);
        rd(A_CLR, d);    chk_eq("R1 clr", d, 0);
        chk_eq("R1 irq", {30'h0, irq_odd, irq_even}, 0);

        // R2: field layout and pin mapping
        wr(A_SEL_LO, 32'hF654_3210, "R2");
        rd(A_SEL_LO, d); chk_eq("R2 sel_lo readback", d, 32'h7654_3210);
        wr(A_SEL_HI, 32'h0000_0054, "R2");
        rd(A_SEL_HI, d); chk_eq("R2 sel_hi readback", d, 32'h0000_0054);
        wr(A_RISE, 32'h0000_FFFF, "R2");
        pins_to(bit_at(pidx(3, 3)) | bit_at(pidx(0, 3)) | bit_at(pidx(4, 8)), "R2");
        rd(A_FLAG, d); chk_eq("R2 mapped flags", d, 32'h0000_0108);
        wr(A_CLR, 32'h0000_FFFF, "R5");
        rd(A_FLAG, d); chk_eq("R5 clear all", d, 0);

        // R10: ch3 now sees a high pin on port 0 right after the switch
        wr(A_SEL_LO, 32'h0, "R10");
        wr(A_SEL_HI, 32'h0, "R10");
        rd(A_FLAG, d); chk_eq("R10 no edge after switch", d, 0);
        pins_to('0, "R4");

        // R3 and R7
        pins_to(bit_at(pidx(0, 0)), "R3");
        rd(A_FLAG, d); chk_eq("R3 rise sets flag", d, 32'h1);
        chk_eq("R7 irq stays low with enables off", {30'h0, irq_odd, irq_even}, 0);
        repeat (3) step(cur_pins, 1'b0, A_FLAG, 32'h0, "R7");
        pins_to('0, "R7");
        rd(A_FLAG, d); chk_eq("R7 flag held", d, 32'h1);

        // R11
        wr(A_FLAG, 32'h0, "R11");
        rd(A_FLAG, d);   chk_eq("R11 flag write ignored", d, 32'h1);
        wr(12'h118, 32'hFFFF_FFFF, "R11");
        rd(12'h118, d);  chk_eq("R11 unmapped reads zero", d, 0);

        // R5
        wr(A_CLR, 32'h0000_FFFE, "R5");
        rd(A_FLAG, d); chk_eq("R5 zero bits keep flag", d, 32'h1);
        rd(A_CLR, d);  chk_eq("R5 alias reads zero", d, 0);
        wr(A_CLR, 32'h1, "R5");
        rd(A_FLAG, d); chk_eq("R5 one bit clears", d, 0);

        // R4
        wr(A_FALL, 32'h0000_FFFF, "R4");
        wr(A_RISE, 32'h0, "R4");
        pins_to(bit_at(pidx(0, 2)), "R4");
        rd(A_FLAG, d); chk_eq("R4 rise disabled", d, 0);
        pins_to('0, "R4");
        rd(A_FLAG, d); chk_eq("R4 fall sets", d, 32'h4);
        wr(A_RISE, 32'h0000_FFFF, "R4");
        wr(A_CLR, 32'h4, "R4");
        pins_to(bit_at(pidx(0, 2)), "R4");
        rd(A_FLAG, d); chk_eq("R4 both enabled rise", d, 32'h4);

        // R6: edge and clear of the same bit in one cycle
        cur_pins = cur_pins | bit_at(pidx(0, 1));
        step(cur_pins, 1'b1, A_CLR, 32'h0000_0002, "R6");
        rd(A_FLAG, d); chk_eq("R6 set wins", d, 32'h6);

        // R8
        wr(A_IEN, 32'h2, "R8");
        chk_eq("R8 odd only", {30'h0, irq_odd, irq_even}, 32'h2);
        wr(A_IEN, 32'h4, "R8");
        chk_eq("R8 even only", {30'h0, irq_odd, irq_even}, 32'h1);
        wr(A_IEN, 32'h0, "R8");
        chk_eq("R8 none", {30'h0, irq_odd, irq_even}, 0);
        pins_to('0, "R8");
        wr(A_CLR, 32'hFFFF, "R8");

        // R9: index 6 then 7 on channel 4
        wr(A_SEL_LO, 32'h0006_0000, "R9");
        begin
            logic [PIN_W-1:0] col4;
            col4 = '0;
            for (int p = 0; p < NUM_PORTS; p++) col4 = col4 | bit_at(pidx(p, 4));
            pins_to(col4, "R9");
            rd(A_FLAG, d); chk_eq("R9 port 6 silent", d, 0);
            pins_to('0, "R9");
            wr(A_SEL_LO, 32'h0007_0000, "R9");
            pins_to(col4, "R9");
            pins_to('0, "R9");
            rd(A_FLAG, d); chk_eq("R9 port 7 silent", d, 0);
        end

        // R10: switch channel 5 between ports at opposite levels
        wr(A_SEL_LO, 32'h0, "R10");
        pins_to(bit_at(pidx(1, 5)), "R10");
        wr(A_SEL_LO, 32'h0010_0000, "R10");
        step(cur_pins, 1'b0, A_FLAG, 32'h0, "R10");
        rd(A_FLAG, d); chk_eq("R10 switch to high port", d, 0);
        wr(A_SEL_LO, 32'h0, "R10");
        step(cur_pins, 1'b0, A_FLAG, 32'h0, "R10");
        rd(A_FLAG, d); chk_eq("R10 switch to low port", d, 0);

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            bit we;
            logic [ADDR_W-1:0] a;
            flip = {($urandom & $urandom & $urandom),
                    ($urandom & $urandom & $urandom),
                    ($urandom & $urandom & $urandom)};
            cur_pins = cur_pins ^ flip;
            we = ($urandom % 8) < 3;
            a  = alist[$urandom % 8];
            step(cur_pins, we, a, $urandom, "R7 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule